// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block generates the word address a synchronous memory uses across a four-beat burst. A command cycle with the load control low captures an external base address and presents it as the first beat. Each later command cycle with the load control high steps to the next beat. Only the two least-significant address bits move between beats, so a burst never leaves its aligned group of four words.

The two low bits follow one of two orders, picked by a mode input that is captured together with the base address. The interleaved order XORs the base offset with the beat number. The linear order adds the beat number to the base offset and wraps modulo four. If a burst is continued past its fourth beat, it wraps to the base offset and repeats the same four-beat pattern. A clock-enable input freezes the whole generator. A command-valid flag marks the cycles that actually carry a command; the generator ignores all other cycles.

The address is registered. A load or step sampled at one rising edge is visible on the output right after that edge.

Top module: `bseq_top`

## Requirements
- R1: While the active-low reset `rstN` is low, `curAddr` is 0. The next burst after reset starts from whatever address is loaded.
- R2: A rising edge with `clkEn`=1, `cmdValid`=1 and `advance`=0 (load) makes `curAddr` equal to `extAddr` right after that edge.
- R3: After a load with `seqMode`=1 (interleaved), the next three continue cycles (`advance`=1) give low bits `base^2'b01`, `base^2'b10` and `base^2'b11`, where `base` is bits [1:0] of the loaded address.
- R4: After a load with `seqMode`=0 (linear), the next three continue cycles give low bits `base+1`, `base+2` and `base+3`, each taken modulo 4.
- R5: On a continue cycle, bits [ADDR_W-1:2] of `curAddr` stay the same, and `extAddr` has no effect.
- R6: The fourth continue cycle after a load brings the low bits back to the base offset. The sequence then repeats in the same order.
- R7: While `clkEn`=0, `curAddr` holds and no input changes the burst state. The next continue after `clkEn` returns yields the beat that would have followed.
- R8: A cycle with `cmdValid`=0 leaves `curAddr` and the beat position unchanged, whatever `advance`, `extAddr` and `seqMode` are.
- R9: `seqMode` is used only at a load. Changing it during a burst does not change the order until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset |
| clkEn | input | 1 | 1 = the generator may act on this edge; 0 = hold everything |
| cmdValid | input | 1 | 1 = this cycle carries a command |
| advance | input | 1 | 0 = load a new base address; 1 = continue the current burst |
| extAddr | input | ADDR_W | External address captured on a load |
| seqMode | input | 1 | Captured on a load: 1 = interleaved (XOR) order, 0 = linear (add, wrap mod 4) order |
| curAddr | output | ADDR_W | Current burst address |

## Verification
The directed cases cover the following failure modes:
- Interleaved and linear bursts that start from a nonzero offset. A design that swapped XOR and add, or let the linear carry spill into bit 2, would produce the wrong word.
- A fifth continue, which exposes a generator that runs off the four-word group instead of wrapping.
- Flipping the mode pin in mid-burst, which catches a design that reads the pin live rather than capturing it at the load.
- Idle cycles and clock-enable gaps, which catch a beat counter that moves when it should not. Such a counter shows up as a skipped beat on the next continue.

Random mixes of these controls, drawn from a fixed seed, are compared against a bench model of the sequence.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  localparam int OFF_W = 2;

  typedef logic [OFF_W-1:0] offset_t;

  typedef struct packed {
    logic    load;
    logic    step;
    offset_t beat;
    logic    ilv;
  } strobe_t;

  function automatic offset_t burstOffset(offset_t baseLow, offset_t beat, logic ilv);
    offset_t sum;
    sum = offset_t'(baseLow + beat);
    return ilv ? (baseLow ^ beat) : sum;
  endfunction

endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    clkEn,
  input  logic    cmdValid,
  input  logic    advance,
  input  logic    seqMode,
  output strobe_t strb
);

  offset_t beatQ;
  logic    ilvQ;
  logic    fire;

  assign fire = clkEn & cmdValid;

  always_comb begin
    strb.load = fire & ~advance;
    strb.step = fire & advance;
    strb.beat = strb.load ? '0 : offset_t'(beatQ + 1'b1);
    strb.ilv  = strb.load ? seqMode : ilvQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatQ <= '0;
      ilvQ  <= 1'b1;
    end else if (strb.load || strb.step) begin
      beatQ <= strb.beat;
      ilvQ  <= strb.ilv;
    end
  end

endmodule

// File: rtl/bseq_path.sv
module bseq_path
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] curAddr
);

  localparam int UP_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] curQ;
  logic [UP_W-1:0]   upperBits;
  offset_t           nextLow;

  assign upperBits = baseQ[ADDR_W-1:OFF_W];
  assign nextLow   = burstOffset(baseQ[OFF_W-1:0], strb.beat, strb.ilv);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      curQ  <= '0;
    end else if (strb.load) begin
      baseQ <= extAddr;
      curQ  <= extAddr;
    end else if (strb.step) begin
      curQ  <= {upperBits, nextLow};
    end
  end

  assign curAddr = curQ;

endmodule

// File: rtl/bseq_top.sv
module bseq_top
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              cmdValid,
  input  logic              advance,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              seqMode,
  output logic [ADDR_W-1:0] curAddr
);

  strobe_t strb;

  bseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clkEn    (clkEn),
    .cmdValid (cmdValid),
    .advance  (advance),
    .seqMode  (seqMode),
    .strb     (strb)
  );

  bseq_path #(.ADDR_W(ADDR_W)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .extAddr (extAddr),
    .curAddr (curAddr)
  );

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEn,
  input logic              cmdValid,
  input logic              advance,
  input logic [ADDR_W-1:0] extAddr,
  input logic              seqMode,
  input logic [ADDR_W-1:0] curAddr
);

  localparam int OFF = 2;

  // R1: reset clears the address
  p_reset_zero_r1: assert property (@(posedge clk) !rstN |=> curAddr == '0);

  // R2: a load presents the external address
  p_load_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && cmdValid && !advance) |=> curAddr == $past(extAddr));

  // R5: upper bits stay put on a continue
  p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && cmdValid && advance) |=> curAddr[ADDR_W-1:OFF] == $past(curAddr[ADDR_W-1:OFF]));

  // R3/R4: every continue moves to a different word in the group
  p_step_moves_r3: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && cmdValid && advance) |=> curAddr[OFF-1:0] != $past(curAddr[OFF-1:0]));

  // R7: clock enable low freezes the output
  p_hold_en_r7: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> $stable(curAddr));

  // R8: a cycle without a command changes nothing
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> $stable(curAddr));

endmodule

bind bseq_top bseq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .clkEn    (clkEn),
  .cmdValid (cmdValid),
  .advance  (advance),
  .extAddr  (extAddr),
  .seqMode  (seqMode),
  .curAddr  (curAddr)
);

// File: tb/sim_bseq_top.sv
module sim_bseq_top;

  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rstN;
  logic          clkEn;
  logic          cmdValid;
  logic          advance;
  logic [AW-1:0] extAddr;
  logic          seqMode;
  logic [AW-1:0] curAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [AW-1:0] mBase;
  logic [AW-1:0] mCur;
  logic [1:0]    mBeat;
  logic          mIlv;

  always #2.5 clk = ~clk;

  bseq_top #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .cmdValid(cmdValid),
    .advance(advance), .extAddr(extAddr), .seqMode(seqMode), .curAddr(curAddr)
  );

  function automatic logic [1:0] expOff(logic [1:0] b, logic [1:0] k, logic ilv);
    logic [1:0] s;
    s = b + k;
    return ilv ? (b ^ k) : s;
  endfunction

  task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: curAddr=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic en, input logic vld, input logic adv,
                       input logic [AW-1:0] a, input logic md, input string tag);
    clkEn = en; cmdValid = vld; advance = adv; extAddr = a; seqMode = md;
    if (en && vld) begin
      if (!adv) begin
        mBase = a; mIlv = md; mBeat = 2'd0; mCur = a;
      end else begin
        mBeat = mBeat + 2'd1;
        mCur  = {mBase[AW-1:2], expOff(mBase[1:0], mBeat, mIlv)};
      end
    end
    @(negedge clk);
    check(curAddr, mCur, tag);
  endtask

  initial begin
    void'($urandom(32'd4711));
    rstN = 1'b0; clkEn = 1'b1; cmdValid = 1'b1; advance = 1'b0;
    extAddr = 20'h5A5A5; seqMode = 1'b0;
    mBase = '0; mCur = '0; mBeat = 2'd0; mIlv = 1'b1;
    repeat (3) @(negedge clk);
    check(curAddr, '0, "R1 reset");
    rstN = 1'b1;

    // R2 + R3: interleaved from offset 2
    apply(1, 1, 0, 20'hABCD2, 1, "R2 load");
    check(curAddr, 20'hABCD2, "R2 literal");
    apply(1, 1, 1, 20'h00000, 1, "R3 beat1");
    check(curAddr, 20'hABCD3, "R3 beat1 literal");
    apply(1, 1, 1, 20'hFFFFF, 1, "R3 beat2");
    check(curAddr, 20'hABCD0, "R3 beat2 literal");
    apply(1, 1, 1, 20'h12345, 1, "R3 beat3");
    check(curAddr, 20'hABCD1, "R5 upper kept, R3 beat3");
    apply(1, 1, 1, 20'h0, 1, "R6 wrap");
    check(curAddr, 20'hABCD2, "R6 wrap literal");

    // R4: linear from offset 3
    apply(1, 1, 0, 20'h12343, 0, "R2 load linear");
    apply(1, 1, 1, 20'h0, 0, "R4 beat1");
    check(curAddr, 20'h12340, "R4 beat1 literal");
    apply(1, 1, 1, 20'h0, 1, "R9 mode flip");
    check(curAddr, 20'h12341, "R9 mode ignored mid-burst");
    apply(1, 1, 1, 20'h0, 1, "R4 beat3");
    check(curAddr, 20'h12342, "R4 beat3 literal");
    apply(1, 1, 1, 20'h0, 0, "R6 linear wrap");
    check(curAddr, 20'h12343, "R6 linear wrap literal");

    // R7: clock enable gap
    apply(1, 1, 0, 20'h00011, 0, "R2 load");
    apply(0, 1, 0, 20'hFFFFF, 1, "R7 held load");
    check(curAddr, 20'h00011, "R7 hold literal");
    apply(0, 1, 1, 20'h0, 1, "R7 held step");
    apply(1, 1, 1, 20'h0, 0, "R7 resume");
    check(curAddr, 20'h00012, "R7 resume literal");

    // R8: idle cycles
    apply(1, 0, 0, 20'h77777, 1, "R8 idle load");
    apply(1, 0, 1, 20'h77777, 1, "R8 idle step");
    check(curAddr, 20'h00012, "R8 idle literal");
    apply(1, 1, 1, 20'h0, 1, "R8 resume");
    check(curAddr, 20'h00013, "R8 resume literal");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic en, vld, adv, md;
      logic [AW-1:0] a;
      en  = ($urandom % 8) != 0;
      vld = ($urandom % 6) != 0;
      adv = ($urandom % 4) != 0;
      md  = $urandom % 2;
      a   = AW'($urandom);
      apply(en, vld, adv, a, md,
            !en ? "R7 rand" : !vld ? "R8 rand" : !adv ? "R2 rand" :
            (mIlv ? "R3 rand" : "R4 rand"));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule